// File: doc/BRIEF.md
# Wake-Up Event Latch

This block captures wake-up events from two independent groups of sources: a group of external pins and a group of internal peripheral interrupt lines. Every source passes through a two-stage synchronizer. Its own polarity bit then picks a rising or a falling transition, and that transition is held in a sticky status bit. Software reads the status, enables the sources it cares about and clears held events by writing ones.

A status bit is set whether or not its source is enabled. An event that arrived while its source was disabled is therefore still held, and it raises the wake output as soon as software enables that source. The wake output is a registered OR of the enabled, held events of both groups. It is meant to drive the power-mode sequencer that sits outside this block.

Top module: `wake_latch_top`

## Requirements
- R1: After reset, every enable bit and every status bit is 0, wake_o is 0, and all pin polarity bits are 0. The internal group's polarity bits reset to parameter INT_POL_RST, which by default is 15'h0288 (bits 3, 7 and 9 rising, all other bits falling).
- R2: Register address bus_addr_i[2] selects the group (0 = pins, 1 = internal) and bus_addr_i[1:0] selects the register: 0 enable, 1 polarity, 2 held status (write-one-to-clear), 3 masked status (read-only). bus_rdata_o is combinational and zero-extended.
- R3: A polarity bit of 1 latches a rising transition of its synchronized source and ignores a falling one. A polarity bit of 0 latches a falling transition and ignores a rising one. Several sources can latch at once.
- R4: A held status bit is set by its selected transition even while its enable bit is 0.
- R5: Writing 1 to a held status bit clears it. Writing 0 leaves the bit unchanged, and writes to the masked status address change nothing.
- R6: The masked status reads as held status AND enable.
- R7: wake_o is 1 on the clock edge after any enabled held bit in either group is 1. Enabling a source whose event is already held raises wake_o on the edge after that write.
- R8: If a transition and a clearing write hit the same bit on the same edge, the bit ends up set.
- R9: A level change on a source input, sampled at one clock edge, shows in the held status after the third clock edge and not after the second.
- R10: The two groups are independent: writes to one group never alter the other group's registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_evt_i | input | PIN_W | External pin event sources (asynchronous) |
| int_evt_i | input | INT_W | Internal interrupt event sources (asynchronous) |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 3 | Register address: group bit and register index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| wake_o | output | 1 | Registered wake request |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the exact edge where a new transition on the same bit is latched. Reaching it depends on the synchronizer depth. The bench first latches the bit once. It then changes the pin just after a falling clock edge, lets two rising edges pass, and places the one-cycle clearing write so that it is sampled on the third edge. Reading the bit back as 1 shows that the set won. The same bit is then cleared alone as a contrast.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_POLARITY = 2'd1,
    REG_HELD     = 2'd2,
    REG_MASKED   = 2'd3
  } wake_reg_e;

  localparam logic GRP_PIN = 1'b0;
  localparam logic GRP_INT = 1'b1;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wake_group.sv
module wake_group #(
  parameter int           W       = 12,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] POL_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         en_we_i,
  input  logic         pol_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] held_o,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] clr_o
);
  logic [W-1:0] evt_s;
  logic [W-1:0] prev_q;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] pol_q, pol_d;
  logic [W-1:0] held_q, held_d;
  logic [W-1:0] hit, clr;

  wake_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (evt_i),
    .q_o   (evt_s)
  );

  // Edge selection per bit: rising when polarity is 1, falling when 0
  assign hit = (pol_q & evt_s & ~prev_q) | (~pol_q & ~evt_s & prev_q);
  assign clr = clr_we_i ? wdata_i : '0;

  always_comb begin
    en_d   = en_we_i  ? wdata_i : en_q;
    pol_d  = pol_we_i ? wdata_i : pol_q;
    // set has priority over clear
    held_d = (held_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      en_q   <= '0;
      pol_q  <= POL_RST;
      held_q <= '0;
    end else begin
      prev_q <= evt_s;
      held_q <= held_d;
      if (en_we_i)  en_q  <= en_d;
      if (pol_we_i) pol_q <= pol_d;
    end
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign held_o = held_q;
  assign hit_o  = hit;
  assign clr_o  = clr;
endmodule

// File: rtl/wake_latch_top.sv
module wake_latch_top
  import wake_pkg::*;
#(
  parameter int               PIN_W       = 12,
  parameter int               INT_W       = 15,
  parameter int               DATA_W      = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [INT_W-1:0] INT_POL_RST = 15'h0288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pin_evt_i,
  input  logic [INT_W-1:0]  int_evt_i,
  input  logic              bus_wr_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wake_o
);
  localparam logic [PIN_W-1:0] PIN_POL_RST = '0;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wake_reg_e reg_sel;
  logic      grp_sel;
  logic      pin_acc, int_acc;

  assign reg_sel = wake_reg_e'(bus_addr_i[1:0]);
  assign grp_sel = bus_addr_i[2];
  assign pin_acc = bus_wr_i && (grp_sel == GRP_PIN);
  assign int_acc = bus_wr_i && (grp_sel == GRP_INT);

  logic [PIN_W-1:0] pin_en, pin_pol, pin_held, pin_hit, pin_clr;
  logic [INT_W-1:0] int_en, int_pol, int_held, int_hit, int_clr;

  wake_group #(.W(PIN_W), .STAGES(SYNC_STAGES), .POL_RST(PIN_POL_RST)) u_pin (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .evt_i    (pin_evt_i),
    .en_we_i  (pin_acc && reg_sel == REG_ENABLE),
    .pol_we_i (pin_acc && reg_sel == REG_POLARITY),
    .clr_we_i (pin_acc && reg_sel == REG_HELD),
    .wdata_i  (bus_wdata_i[PIN_W-1:0]),
    .en_o     (pin_en),
    .pol_o    (pin_pol),
    .held_o   (pin_held),
    .hit_o    (pin_hit),
    .clr_o    (pin_clr)
  );

  wake_group #(.W(INT_W), .STAGES(SYNC_STAGES), .POL_RST(INT_POL_RST)) u_int (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .evt_i    (int_evt_i),
    .en_we_i  (int_acc && reg_sel == REG_ENABLE),
    .pol_we_i (int_acc && reg_sel == REG_POLARITY),
    .clr_we_i (int_acc && reg_sel == REG_HELD),
    .wdata_i  (bus_wdata_i[INT_W-1:0]),
    .en_o     (int_en),
    .pol_o    (int_pol),
    .held_o   (int_held),
    .hit_o    (int_hit),
    .clr_o    (int_clr)
  );

  logic [PIN_W-1:0] pin_word;
  logic [INT_W-1:0] int_word;

  always_comb begin
    case (reg_sel)
      REG_ENABLE:   begin pin_word = pin_en;            int_word = int_en;            end
      REG_POLARITY: begin pin_word = pin_pol;           int_word = int_pol;           end
      REG_HELD:     begin pin_word = pin_held;          int_word = int_held;          end
      default:      begin pin_word = pin_held & pin_en; int_word = int_held & int_en; end
    endcase
    bus_rdata_o = '0;
    if (grp_sel == GRP_PIN) bus_rdata_o[PIN_W-1:0] = pin_word;
    else                    bus_rdata_o[INT_W-1:0] = int_word;
  end

  logic wake_d, wake_q;
  assign wake_d = (|(pin_held & pin_en)) | (|(int_held & int_en));

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) wake_q <= 1'b0;
    else          wake_q <= wake_d;
  end
  assign wake_o = wake_q;
endmodule

// File: rtl/wake_latch_chk.sv
module wake_latch_chk #(
  parameter int PIN_W = 12,
  parameter int INT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wake_o,
  input logic [PIN_W-1:0] pin_en,
  input logic [PIN_W-1:0] pin_held,
  input logic [PIN_W-1:0] pin_hit,
  input logic [PIN_W-1:0] pin_clr,
  input logic [INT_W-1:0] int_en,
  input logic [INT_W-1:0] int_held,
  input logic [INT_W-1:0] int_hit,
  input logic [INT_W-1:0] int_clr
);
  // a selected transition always lands in the held status, even with a clear pending
  assert_pin_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_hit) |=> ((pin_held & $past(pin_hit)) == $past(pin_hit)));
  assert_int_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_hit) |=> ((int_held & $past(int_hit)) == $past(int_hit)));

  // a clear without a coincident transition empties the bit
  assert_pin_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pin_clr & ~pin_hit)) |=> ((pin_held & $past(pin_clr & ~pin_hit)) == '0));
  assert_int_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(int_clr & ~int_hit)) |=> ((int_held & $past(int_clr & ~int_hit)) == '0));

  // held bits rise only from a selected transition
  assert_pin_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_held & ~$past(pin_held) & ~$past(pin_hit)) == '0));
  assert_int_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_held & ~$past(int_held) & ~$past(int_hit)) == '0));

  // wake follows enabled held events one edge later
  assert_wake_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o == $past((|(pin_held & pin_en)) | (|(int_held & int_en))));
endmodule

bind wake_latch_top wake_latch_chk #(.PIN_W(PIN_W), .INT_W(INT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .wake_o   (wake_o),
  .pin_en   (pin_en),
  .pin_held (pin_held),
  .pin_hit  (pin_hit),
  .pin_clr  (pin_clr),
  .int_en   (int_en),
  .int_held (int_held),
  .int_hit  (int_hit),
  .int_clr  (int_clr)
);

// File: tb/wake_latch_top_tb.sv
module wake_latch_top_tb;
  localparam int PIN_W  = 12;
  localparam int INT_W  = 15;
  localparam int DATA_W = 32;
  localparam logic [2:0] A_PEN = 3'd0, A_PPOL = 3'd1, A_PHELD = 3'd2, A_PMASK = 3'd3;
  localparam logic [2:0] A_IEN = 3'd4, A_IPOL = 3'd5, A_IHELD = 3'd6, A_IMASK = 3'd7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PIN_W-1:0]  pin_evt;
  logic [INT_W-1:0]  int_evt;
  logic              bus_wr;
  logic [2:0]        bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  wake_latch_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_evt_i   (pin_evt),
    .int_evt_i   (int_evt),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .wake_o      (wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic read_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    read_check("R1 pin enable", A_PEN, 0);
    read_check("R1 pin polarity", A_PPOL, 0);
    read_check("R1 pin held", A_PHELD, 0);
    read_check("R1 int enable", A_IEN, 0);
    read_check("R1 int polarity", A_IPOL, 32'h0288);
    read_check("R1 int held", A_IHELD, 0);
    read_check("R2 int masked", A_IMASK, 0);
    check("R1 wake", wake, 0);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    bus_write(A_PPOL, 32'h1);
    @(negedge clk); pin_evt[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    bus_read(A_PHELD, d); check("R9 not after second edge", d, 0);
    @(posedge clk); #1;
    bus_read(A_PHELD, d); check("R9 held after third edge", d, 1);
    cycles(2);
    read_check("R4 held while disabled", A_PHELD, 1);
    read_check("R6 masked with enable 0", A_PMASK, 0);
    check("R7 wake stays low while disabled", wake, 0);
  endtask

  task automatic t_enable_pending;
    bus_write(A_PEN, 32'h1);
    check("R7 wake not before next edge", wake, 0);
    cycles(1);
    check("R7 wake after enabling pending", wake, 1);
    read_check("R6 masked with enable 1", A_PMASK, 1);
  endtask

  task automatic t_clear;
    bus_write(A_PHELD, 32'h0);
    read_check("R5 write zero keeps held", A_PHELD, 1);
    bus_write(A_PMASK, 32'hFFF);
    read_check("R5 masked write ignored", A_PHELD, 1);
    bus_write(A_PHELD, 32'h1);
    read_check("R5 write one clears", A_PHELD, 0);
    cycles(1);
    check("R7 wake drops after clear", wake, 0);
    @(negedge clk); pin_evt[0] = 1'b0;
    cycles(5);
    read_check("R3 falling ignored when rising", A_PHELD, 0);
    bus_write(A_PEN, 32'h0);
  endtask

  task automatic t_falling;
    @(negedge clk); pin_evt[1] = 1'b1;
    cycles(5);
    read_check("R3 rising ignored when falling", A_PHELD, 0);
    @(negedge clk); pin_evt[1] = 1'b0;
    cycles(5);
    read_check("R3 falling latched", A_PHELD, 32'h2);
    bus_write(A_PHELD, 32'hFFF);
  endtask

  task automatic t_multi;
    bus_write(A_PPOL, 32'hFFF);
    @(negedge clk); pin_evt = 12'hAA0;
    cycles(5);
    read_check("R3 several rising at once", A_PHELD, 32'hAA0);
    @(negedge clk); pin_evt = '0;
    cycles(5);
    read_check("R3 falls ignored with all rising", A_PHELD, 32'hAA0);
    bus_write(A_PHELD, 32'hFFF);
    read_check("R5 clear all", A_PHELD, 0);
  endtask

  task automatic t_internal;
    @(negedge clk); int_evt[3] = 1'b1; int_evt[0] = 1'b1;
    cycles(5);
    read_check("R1 default rising bit3", A_IHELD, 32'h8);
    read_check("R10 pin group untouched", A_PHELD, 0);
    bus_write(A_PHELD, 32'hFFF);
    read_check("R10 pin clear leaves int", A_IHELD, 32'h8);
    @(negedge clk); int_evt = '0;
    cycles(5);
    read_check("R1 default falling bit0", A_IHELD, 32'h9);
    bus_write(A_IEN, 32'h1);
    read_check("R10 pin enable untouched", A_PEN, 0);
    cycles(1);
    check("R7 wake from internal group", wake, 1);
    read_check("R6 int masked", A_IMASK, 32'h1);
    bus_write(A_IHELD, 32'h7FFF);
    cycles(1);
    check("R7 wake drops after int clear", wake, 0);
    read_check("R5 int cleared", A_IHELD, 0);
    bus_write(A_IEN, 32'h0);
  endtask

  task automatic t_set_wins;
    @(negedge clk); pin_evt[2] = 1'b1;
    cycles(5);
    @(negedge clk); pin_evt[2] = 1'b0;
    cycles(5);
    read_check("R8 prelatched", A_PHELD, 32'h4);
    @(negedge clk); pin_evt[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    bus_write(A_PHELD, 32'h4);
    read_check("R8 set beats clear", A_PHELD, 32'h4);
    bus_write(A_PHELD, 32'h4);
    read_check("R8 clear alone", A_PHELD, 0);
    @(negedge clk); pin_evt[2] = 1'b0;
    cycles(5);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_evt = '0; int_evt = '0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cycles(3);
    @(negedge clk); rst_n = 1'b1;
    cycles(4);
    t_reset;
    t_latency;
    t_enable_pending;
    t_clear;
    t_falling;
    t_multi;
    t_internal;
    t_set_wins;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule